// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block collects the bytes of one page write into a small staging buffer and then programs them into a byte-wide nonvolatile array in a single timed write cycle. A serial front end supplies a start address, then a stream of data bytes, then a commit request when the transfer ends. The buffer holds one 16-byte page. Each received byte goes to the slot named by a 4-bit in-page pointer. The pointer then advances and wraps inside the page, and the page number never changes.

On commit, every slot that received a byte since the last address load is written into the array in one step. The step happens at the end of a write cycle whose length is a parameter counted in system clock cycles. A busy flag stays high for that whole time, and address loads, byte writes and commits are refused while it is high. Slots that received nothing leave their array locations unchanged. A commit with an empty buffer does nothing. The array is a register memory that reset fills with FFh. A combinational read port exposes it.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy` is 0 and every array location reads FFh on `rd_data`.
- R2: An accepted `addr_load` sets the page number to `addr_in[ADDR_W-1:4]`, sets the in-page pointer to `addr_in[3:0]`, and marks every slot empty.
- R3: Each accepted `byte_we` stores `byte_in` in the slot at the pointer and advances the pointer by one modulo 16. After slot 15 comes slot 0 of the same page, and the page number stays the same.
- R4: When more than 16 bytes arrive before a commit, each later byte replaces the earlier byte in its slot. The last byte written to a slot is the one that gets programmed.
- R5: A commit accepted while at least one slot is full raises `busy` at the next clock edge. `busy` then stays high for exactly `TWR_CYCLES` clock cycles.
- R6: All full slots are written to the array together at the edge where `busy` falls. During `busy`, reads return the old contents.
- R7: Array locations of the page whose slots are empty at commit keep their previous contents.
- R8: A commit with every slot empty leaves `busy` at 0 and the array unchanged.
- R9: While `busy` is 1, `addr_load`, `byte_we` and `commit` are ignored. They change neither the buffer, the pointer nor the array.
- R10: Every slot is marked empty at the end of each write cycle, so a following commit with no new byte starts no cycle.
- R11: When several requests arrive in the same cycle, `commit` takes priority over `addr_load`, and `addr_load` takes priority over `byte_we`. Only the highest-priority request takes effect.
- R12: `rd_data` shows the array byte at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load start address from `addr_in` |
| addr_in | input | ADDR_W | Start byte address |
| byte_we | input | 1 | Store `byte_in` at the in-page pointer |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | End of transfer; start write cycle |
| busy | output | 1 | Write cycle in progress |
| rd_addr | input | ADDR_W | Read address into the array |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bench builds the block with `ADDR_W` = 6 and `TWR_CYCLES` = 7. That gives an array of four pages, 64 bytes in all, and a short write cycle. With these values it sweeps every page against several start offsets and byte counts, from a single byte up to 20 bytes. The 20-byte case forces pointer wrap and overwrite. After every write cycle it compares all 64 array bytes with an arithmetic model, so each run also confirms that neighbouring pages and empty slots were left alone. The short cycle lets it measure the exact busy length many times, and it lets it aim requests into the busy window and at same-cycle collisions.

// File: rtl/pgw_pkg.sv
// Package: shared constants and types for the page write buffer.
// Assumes byte-wide data and a fixed 16-byte page.
package pgw_pkg;
    localparam int DATA_W  = 8;
    localparam int PAGE_AW = 4;
    localparam int PAGE_N  = 1 << PAGE_AW;

    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [PAGE_AW-1:0] slot_idx_t;
endpackage

// File: rtl/pgw_slot_buffer.sv
// Slot buffer: holds one page of staged bytes, a valid bit per slot,
// the page number and the in-page pointer. Assumes the caller gates
// load/put/clear so that at most one is active in a cycle.
module pgw_slot_buffer
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [ADDR_W-1:0]           load_addr,
    input  logic                        put_en,
    input  byte_t                       put_data,
    input  logic                        clear_en,
    output logic [ADDR_W-PAGE_AW-1:0]   page_o,
    output logic [PAGE_N-1:0]           valid_o,
    output byte_t [PAGE_N-1:0]          slots_o
);
    localparam int PG_W = ADDR_W - PAGE_AW;

    logic [PG_W-1:0]   page_q;
    slot_idx_t         ptr_q;
    logic [PAGE_N-1:0] valid_q;
    byte_t [PAGE_N-1:0] slots_q;

    // Page number and pointer: loaded from the start address, pointer steps on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else if (load_en) begin
            page_q <= load_addr[ADDR_W-1:PAGE_AW];
            ptr_q  <= load_addr[PAGE_AW-1:0];
        end else if (put_en) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    // One register pair per slot: data byte and its valid flag.
    for (genvar s = 0; s < PAGE_N; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots_q[s] <= '0;
                valid_q[s] <= 1'b0;
            end else if (load_en || clear_en) begin
                valid_q[s] <= 1'b0;
            end else if (put_en && (ptr_q == slot_idx_t'(s))) begin
                slots_q[s] <= put_data;
                valid_q[s] <= 1'b1;
            end
        end
    end

    assign page_o  = page_q;
    assign valid_o = valid_q;
    assign slots_o = slots_q;

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        put_en && !load_en |=> ptr_q == $past(ptr_q) + 1'b1);
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(page_q));
    p_slot_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        put_en && !load_en && !clear_en |=> slots_q[$past(ptr_q)] == $past(put_data));
    p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en || load_en |=> valid_q == '0);
endmodule

// File: rtl/pgw_cycle_timer.sv
// Write-cycle timer: raises busy on start and drops it after CYCLES
// clock cycles, pulsing expire in the last busy cycle.
// Assumes start is only asserted while busy is low; CYCLES >= 1.
module pgw_cycle_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Countdown: load on start, decrement while busy, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy   = busy_q;
    assign expire = busy_q && (cnt_q == '0);

    p_start_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && cnt_q != '0 |=> busy_q);
    p_fall_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/pgw_nv_array.sv
// Nonvolatile array model: register memory filled with FFh at reset,
// programmed one page of slots at a time, read combinationally.
// Assumes the write strobe is a single-cycle pulse.
module pgw_nv_array
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-PAGE_AW-1:0]   wr_page,
    input  logic [PAGE_N-1:0]           wr_valid,
    input  byte_t [PAGE_N-1:0]          wr_slots,
    input  logic [ADDR_W-1:0]           rd_addr,
    output byte_t                       rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem_q [DEPTH];

    // Erase on reset; on the strobe write every valid slot of the page at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            for (int s = 0; s < PAGE_N; s++) begin
                if (wr_valid[s]) mem_q[{wr_page, slot_idx_t'(s)}] <= wr_slots[s];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
// Top: page write buffer and commit sequencer. Accepts requests only
// while not busy, with priority commit > address load > byte write.
// Assumes requests are single-cycle pulses from the serial front end.
module eeprom_page_writer
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int TWR_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_we,
    input  logic [7:0]        byte_in,
    input  logic              commit,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int PG_W = ADDR_W - PAGE_AW;

    logic               expire;
    logic [PG_W-1:0]    page;
    logic [PAGE_N-1:0]  valid;
    byte_t [PAGE_N-1:0] slots;
    logic               commit_go, load_go, put_go;

    // Request arbitration: refuse all while busy, then commit > load > byte.
    always_comb begin
        commit_go = commit && !busy && (|valid);
        load_go   = addr_load && !busy && !commit;
        put_go    = byte_we && !busy && !commit && !addr_load;
    end

    pgw_slot_buffer #(.ADDR_W(ADDR_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_go),
        .load_addr (addr_in),
        .put_en    (put_go),
        .put_data  (byte_in),
        .clear_en  (expire),
        .page_o    (page),
        .valid_o   (valid),
        .slots_o   (slots)
    );

    pgw_cycle_timer #(.CYCLES(TWR_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (commit_go),
        .busy   (busy),
        .expire (expire)
    );

    pgw_nv_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (expire),
        .wr_page  (page),
        .wr_valid (valid),
        .wr_slots (slots),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    p_empty_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !busy && valid == '0 |=> !busy);
    p_commit_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !busy && valid != '0 |=> busy);
    p_frozen_buffer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !expire |=> $stable(valid) && $stable(page));
endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
    localparam int AW  = 6;
    localparam int TWR = 7;
    localparam int NB  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_we = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          commit = 1'b0;
    logic          busy;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0] exp_mem [NB];
    logic [7:0] bdat [16];
    logic       bval [16];
    int         bpage = 0;
    int         bptr = 0;

    eeprom_page_writer #(.ADDR_W(AW), .TWR_CYCLES(TWR)) uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_we(byte_we), .byte_in(byte_in), .commit(commit), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < NB; a++) begin
            rd_addr = AW'(a);
            #0.5;
            check(req, int'(rd_data), int'(exp_mem[a]));
        end
    endtask

    task automatic load(input int a, input bit also_byte);
        addr_load = 1'b1; addr_in = AW'(a);
        byte_we = also_byte; byte_in = 8'hA5;
        @(negedge clk);
        addr_load = 1'b0; byte_we = 1'b0;
        bpage = a >> 4; bptr = a & 15;
        for (int s = 0; s < 16; s++) bval[s] = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        byte_we = 1'b1; byte_in = b;
        @(negedge clk);
        byte_we = 1'b0;
        bdat[bptr] = b; bval[bptr] = 1'b1; bptr = (bptr + 1) % 16;
    endtask

    // Commit, optionally with a colliding byte/load; measure busy; check array.
    task automatic do_commit(input bit also_byte, input bit also_load, input string req);
        bit any = 1'b0;
        int first = -1;
        int cnt = 0;
        for (int s = 0; s < 16; s++) if (bval[s]) begin any = 1'b1; if (first < 0) first = s; end
        commit = 1'b1; byte_we = also_byte; byte_in = 8'h3C;
        addr_load = also_load; addr_in = '0;
        @(negedge clk);
        commit = 1'b0; byte_we = 1'b0; addr_load = 1'b0;
        if (any) begin
            rd_addr = AW'(bpage * 16 + first);
            #0.5;
            check("R6 old data while busy", int'(rd_data), int'(exp_mem[bpage * 16 + first]));
            while (busy && cnt < 100) begin
                cnt++;
                @(negedge clk);
            end
            check({"R5 busy length ", req}, cnt, TWR);
            for (int s = 0; s < 16; s++) begin
                if (bval[s]) exp_mem[bpage * 16 + s] = bdat[s];
                bval[s] = 1'b0;
            end
        end else begin
            for (int k = 0; k < 3; k++) begin
                check({"R8 no busy on empty commit ", req}, int'(busy), 0);
                @(negedge clk);
            end
        end
        check_mem({req, " R3 R4 R6 R7 array"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int offs [3];
        int cnts [4];
        int seq;
        offs = '{0, 5, 15};
        cnts = '{1, 3, 16, 20};
        seq = 0;
        for (int a = 0; a < NB; a++) exp_mem[a] = 8'hFF;
        for (int s = 0; s < 16; s++) begin bval[s] = 1'b0; bdat[s] = '0; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R12 read port
        check("R1 busy after reset", int'(busy), 0);
        check_mem("R1 R12 erased array");

        // R8 empty commit right after reset
        do_commit(1'b0, 1'b0, "R8 reset");

        // Sweep pages x offsets x counts (R2 R3 R4 R5 R6 R7 R10)
        for (int p = 0; p < NB / 16; p++) begin
            for (int oi = 0; oi < 3; oi++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    load(p * 16 + offs[oi], 1'b0);
                    for (int k = 0; k < cnts[ci]; k++)
                        put(8'((p * 37 + offs[oi] * 11 + cnts[ci] * 5 + k * 13 + seq * 7) & 255));
                    seq++;
                    do_commit(1'b0, 1'b0, "R2 sweep");
                    // R10 valid bits cleared: second commit starts nothing
                    if (ci == 0) do_commit(1'b0, 1'b0, "R10 recommit");
                end
            end
        end

        // R9: requests during busy are ignored
        load(16 + 3, 1'b0);
        put(8'h11); put(8'h22);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        check("R9 busy raised", int'(busy), 1);
        addr_load = 1'b1; addr_in = AW'(40);
        @(negedge clk);
        addr_load = 1'b0; byte_we = 1'b1; byte_in = 8'h99;
        @(negedge clk);
        byte_we = 1'b0; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        while (busy) @(negedge clk);
        for (int s = 0; s < 16; s++) begin
            if (bval[s]) exp_mem[bpage * 16 + s] = bdat[s];
            bval[s] = 1'b0;
        end
        check_mem("R9 after busy");
        do_commit(1'b0, 1'b0, "R9 R10 ignored byte");
        put(8'h5E);                       // pointer continues at old page/offset 5
        do_commit(1'b0, 1'b0, "R9 ignored load");
        check("R9 pointer kept", int'(exp_mem[16 + 5]), 8'h5E);

        // R11: commit beats byte and load in the same cycle
        load(32 + 9, 1'b0);
        put(8'h77);
        do_commit(1'b1, 1'b1, "R11 commit wins");
        // R11: load beats byte in the same cycle
        load(48 + 2, 1'b1);
        put(8'h42);
        do_commit(1'b0, 1'b0, "R11 load wins");
        check("R11 byte at loaded offset", int'(exp_mem[48 + 2]), 8'h42);
        check("R2 R11 colliding byte dropped", int'(exp_mem[48 + 3]) == 8'hA5 ? 1 : 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule